// File: doc/BRIEF.md
# Multi-Lane Link Synchronization Monitor

This block watches the code-group synchronization phase reported by each lane of a multi-lane serial link and decides when the link as a whole can be treated as synchronized. Each lane reports one of three phases: initial, checking or data. A link enable starts the qualification. The link is declared synchronized only after every participating lane has reported the data phase on a long, unbroken run of clock cycles. A single cycle in which any participating lane drops out of the data phase starts the run over.

The block also counts lane error events. Events seen before the link reaches the synchronized state come from bring-up and do not matter, so the counter is zeroed at the moment the link becomes synchronized. From then on, events are kept until the link is reset. While the link enable is low, events are not counted. A lane mask removes unused lanes from both the readiness check and the error count.

Top module: `link_sync_monitor`

## Requirements
- R1: Each lane reports its phase on two bits of `lane_phase` (lane i at bits [2i+1:2i]): 2'b00 initial, 2'b01 checking, 2'b10 data. Only 2'b10 counts as ready, and the unused code 2'b11 counts as not ready.
- R2: `link_state` is encoded as 2'b00 reset, 2'b01 waiting and 2'b10 synchronized. While `rst_n` is low at a clock edge, the state becomes reset and `err_count` becomes 0.
- R3: In the reset state with `link_enable` high, the link moves to waiting on the next clock edge.
- R4: In waiting, the link moves to synchronized on the edge that completes QUAL_CYCLES (default 256) consecutive clock edges in waiting where every unmasked lane is ready.
- R5: A waiting-state edge on which any unmasked lane is not ready sets the consecutive count back to zero, so a full new run of QUAL_CYCLES ready edges is then required.
- R6: A lane whose `lane_mask` bit is 0 is excluded from the readiness check and from error counting. With all mask bits 0, the readiness check is always met.
- R7: While `link_enable` is high, each clock edge adds to `err_count` the number of unmasked lanes whose `lane_error` bit is 1.
- R8: While `link_enable` is low, `err_count` holds its value and error events are ignored.
- R9: On the edge where the link enters synchronized, `err_count` becomes 0, and events on that edge are discarded.
- R10: Once synchronized, the link stays synchronized, regardless of lane phases, until `link_enable` goes low or reset. Events counted while synchronized are kept.
- R11: A clock edge with `link_enable` low puts the link in the reset state and discards any qualification progress.
- R12: `err_count` saturates at its all-ones value (ERR_W bits, default 32) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_enable | input | 1 | Enables qualification and error counting |
| lane_mask | input | NUM_LANES | 1 = lane participates |
| lane_phase | input | 2*NUM_LANES | Per-lane synchronization phase code |
| lane_error | input | NUM_LANES | Per-lane error event, one per cycle |
| link_state | output | 2 | Link state code |
| err_count | output | ERR_W | Saturating error event count |

## Verification
The qualification count is hidden, so an error in it shows only as a synchronized state that arrives on the wrong edge. A count that does not restart after a dropout makes the link synchronize early, before the 256th edge of the new run. A count that misses ready edges makes it synchronize late. The bench therefore compares the state on every cycle and catches a shift of even one edge. A wrong clear or wrong gating of the error counter shows in `err_count` on the first cycle with an event after the error.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    LINK_RESET = 2'b00,
    LINK_WAIT  = 2'b01,
    LINK_SYNC  = 2'b10
  } link_state_t;

  localparam logic [1:0] PHASE_DATA = 2'b10;

endpackage

// File: rtl/lsm_lane_ready.sv
module lsm_lane_ready #(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0]   mask,
  input  logic [2*NUM_LANES-1:0] phase,
  output logic                   all_ready
);
  import lsm_pkg::*;

  logic [NUM_LANES-1:0] lane_ok;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_ok[i] = !mask[i] || (phase[2*i+1:2*i] == PHASE_DATA);
  end

  assign all_ready = &lane_ok;

endmodule

// File: rtl/lsm_qual_counter.sv
module lsm_qual_counter #(
  parameter int LIMIT = 256,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (count != LIM) count <= count + 1'b1;
  end

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

  // R4
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM);

endmodule

// File: rtl/lsm_err_accum.sv
module lsm_err_accum #(
  parameter int NUM_LANES = 4,
  parameter int ERR_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 discard,
  input  logic [NUM_LANES-1:0] events,
  output logic [ERR_W-1:0]     count
);
  localparam logic [ERR_W:0] MAXV = {1'b0, {ERR_W{1'b1}}};

  function automatic logic [ERR_W:0] popcount(input logic [NUM_LANES-1:0] v);
    logic [ERR_W:0] n;
    n = '0;
    for (int i = 0; i < NUM_LANES; i++) n = n + (ERR_W+1)'(v[i]);
    return n;
  endfunction

  function automatic logic [ERR_W-1:0] sat_add(input logic [ERR_W-1:0] a,
                                               input logic [ERR_W:0]   b);
    logic [ERR_W:0] s;
    s = {1'b0, a} + b;
    return (s > MAXV) ? {ERR_W{1'b1}} : s[ERR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (!enable) count <= count;
    else if (discard) count <= '0;
    else              count <= sat_add(count, popcount(events));
  end

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count));

  // R12
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !discard && count == {ERR_W{1'b1}}) |=> count == {ERR_W{1'b1}});

endmodule

// File: rtl/link_sync_monitor.sv
module link_sync_monitor #(
  parameter int NUM_LANES   = 4,
  parameter int QUAL_CYCLES = 256,
  parameter int ERR_W       = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   link_enable,
  input  logic [NUM_LANES-1:0]   lane_mask,
  input  logic [2*NUM_LANES-1:0] lane_phase,
  input  logic [NUM_LANES-1:0]   lane_error,
  output logic [1:0]             link_state,
  output logic [ERR_W-1:0]       err_count
);
  import lsm_pkg::*;

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYCLES - 1);

  link_state_t          state_q, state_d;
  logic                 all_ready;
  logic                 qual_clear;
  logic                 qual_done;
  logic [QW-1:0]        qual_cnt;
  logic [NUM_LANES-1:0] counted_events;

  lsm_lane_ready #(.NUM_LANES(NUM_LANES)) u_ready (
    .mask      (lane_mask),
    .phase     (lane_phase),
    .all_ready (all_ready)
  );

  assign qual_clear = !link_enable || (state_q != LINK_WAIT) || !all_ready;
  assign qual_done  = (state_q == LINK_WAIT) && all_ready && (qual_cnt == QLAST);

  lsm_qual_counter #(.LIMIT(QUAL_CYCLES)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (qual_clear),
    .count (qual_cnt)
  );

  always_comb begin
    state_d = state_q;
    if (!link_enable) state_d = LINK_RESET;
    else begin
      case (state_q)
        LINK_RESET: state_d = LINK_WAIT;
        LINK_WAIT:  if (qual_done) state_d = LINK_SYNC;
        LINK_SYNC:  state_d = LINK_SYNC;
        default:    state_d = LINK_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LINK_RESET;
    else        state_q <= state_d;
  end

  assign counted_events = lane_error & lane_mask;

  lsm_err_accum #(.NUM_LANES(NUM_LANES), .ERR_W(ERR_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (link_enable),
    .discard (qual_done),
    .events  (counted_events),
    .count   (err_count)
  );

  assign link_state = state_q;

  // R4
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != LINK_SYNC) ##1 (state_q == LINK_SYNC) |->
      $past(state_q == LINK_WAIT && all_ready && qual_cnt == QLAST));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LINK_WAIT && link_enable) ##1 (state_q == LINK_SYNC) |->
      err_count == '0);

  // R11
  disable_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_enable |=> state_q == LINK_RESET);

  // R10
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LINK_SYNC && link_enable) |=> state_q == LINK_SYNC);

  // R3
  wait_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LINK_RESET && link_enable) |=> state_q == LINK_WAIT);

endmodule

// File: tb/link_sync_monitor_test.sv
`timescale 1ns/1ps
module link_sync_monitor_test;
  localparam int NL = 4;
  localparam int QC = 256;
  localparam int EW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          link_enable = 1'b0;
  logic [NL-1:0] lane_mask = '1;
  logic [2*NL-1:0] lane_phase = '0;
  logic [NL-1:0] lane_error = '0;
  logic [1:0]    link_state;
  logic [EW-1:0] err_count;

  link_sync_monitor #(.NUM_LANES(NL), .QUAL_CYCLES(QC), .ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .link_enable(link_enable), .lane_mask(lane_mask),
    .lane_phase(lane_phase), .lane_error(lane_error),
    .link_state(link_state), .err_count(err_count)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  string req = "R2";
  int m_state = 0;
  int m_run = 0;
  int m_err = 0;
  bit started = 0;
  bit done = 0;
  int err_pct = 0;
  logic [NL-1:0] err_sel = '1;

  // Reference model: state codes 0 reset, 1 waiting, 2 synchronized.
  always @(posedge clk) begin
    int ready, ev, maxv;
    maxv = (1 << EW) - 1;
    ready = 1; ev = 0;
    for (int i = 0; i < NL; i++) begin
      if (lane_mask[i] && lane_phase[2*i +: 2] != 2'b10) ready = 0;
      if (lane_mask[i] && lane_error[i]) ev++;
    end
    started = 1;
    if (!rst_n) begin
      m_state = 0; m_run = 0; m_err = 0;
    end else if (!link_enable) begin
      m_state = 0; m_run = 0;
    end else if (m_state == 0) begin
      m_state = 1; m_run = 0;
      m_err = (m_err + ev > maxv) ? maxv : m_err + ev;
    end else if (m_state == 1 && ready && m_run + 1 == QC) begin
      m_state = 2; m_err = 0;
    end else begin
      if (m_state == 1) m_run = ready ? m_run + 1 : 0;
      m_err = (m_err + ev > maxv) ? maxv : m_err + ev;
    end
  end

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (started) begin
        checks++;
        if (int'(link_state) != m_state || int'(err_count) != m_err) begin
          fails++;
          $display("FAIL %s: state=%0d err=%0d expected state=%0d err=%0d",
                   req, link_state, err_count, m_state, m_err);
        end
      end
      for (int i = 0; i < NL; i++)
        lane_error[i] = err_sel[i] && (($urandom % 100) < err_pct);
    end
  endtask

  task automatic all_phase(input logic [1:0] p);
    for (int i = 0; i < NL; i++) lane_phase[2*i +: 2] = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2: reset holds everything at zero even with enable and errors
    req = "R2"; link_enable = 1; err_pct = 50;
    cycles(4);
    rst_n = 1;
    // R3 and R7: enable with lanes in initial phase, errors counted
    req = "R3/R7"; all_phase(2'b00);
    cycles(12);
    // R4 and R5: partial run, one-cycle dropout via unused code, full run
    req = "R5"; all_phase(2'b10);
    cycles(200);
    lane_phase[3:2] = 2'b11;   // R1 unused code is not ready
    cycles(1);
    all_phase(2'b10);
    cycles(255);
    req = "R5"; lane_phase[1:0] = 2'b01;
    cycles(1);
    all_phase(2'b10);
    req = "R4/R9";
    cycles(QC + 3);
    // R10: sticky synchronized state with dropouts, errors kept
    req = "R10"; all_phase(2'b00);
    cycles(20);
    // R8 and R11: disable, errors ignored, back to reset
    req = "R8/R11"; link_enable = 0; err_pct = 80;
    cycles(20);
    // R6: lane 3 masked and stuck in initial phase, its errors ignored
    req = "R6"; link_enable = 1; lane_mask = 4'b0111; all_phase(2'b10);
    lane_phase[7:6] = 2'b00; err_pct = 30;
    cycles(QC + 10);
    // R6: all lanes masked, readiness vacuous
    req = "R6"; link_enable = 0; cycles(2);
    lane_mask = '0; all_phase(2'b01); link_enable = 1;
    cycles(QC + 5);
    // R12: saturation after synchronization
    req = "R12"; lane_mask = '1; err_pct = 90;
    cycles(60);
    // R2: reset clears a saturated counter
    req = "R2"; rst_n = 0; cycles(3); rst_n = 1; err_pct = 0;
    cycles(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule